// File: doc/BRIEF.md
# Branch Condition and Next-PC Unit

This unit sits next to an 8-bit processor's instruction sequencer. For each control-transfer opcode it takes the flag bits (zero, carry, parity, sign), the current program counter, the HL pair, the 16-bit instruction operand and the value at the top of the stack. From these it decides whether the transfer is taken, chooses the next program counter, and tells the sequencer whether a return address must be pushed or the stack top popped. It also gives the number of machine states the instruction costs, so that taken and untaken conditional calls and returns are charged correctly.

The sequencer raises `issue_valid` for one cycle with the opcode and its operands. One clock later the unit presents its registered result. The result fields hold until the next issue. The push and pop requests are one-cycle strobes. The stack memory and instruction fetch belong to the sequencer.

Top module: `brc_nextpc`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs become zero.
- R2: The condition field is opcode bits [5:3]. Bits [2:1] select the flag (00 zero, 01 carry, 10 parity, 11 sign) and bit 0 gives the value that flag must have for the condition to be true. This yields 000 not zero, 001 zero, 010 no carry, 011 carry, 100 parity odd (parity flag clear), 101 parity even, 110 plus, 111 minus.
- R3: Opcode 0xC3 always jumps to `operand`. An opcode of form 11ccc010 jumps to `operand` when its condition is true and otherwise goes to pc+3. Both cost 10 states and request no push or pop.
- R4: Opcode 0xCD pushes pc+3 on `push_data`, loads `operand` and costs 17. An opcode of form 11ccc100 does the same when its condition is true. When the condition is false it goes to pc+3, costs 11 and does not push.
- R5: Opcode 0xC9 pops, loads `stack_top` and costs 10. An opcode of form 11ccc000 pops and loads `stack_top` at cost 11 when its condition is true. When the condition is false it goes to pc+1 at cost 5 without popping.
- R6: An opcode of form 11nnn111 pushes pc+1 and loads the vector nnn×8 (binary 0000 0000 00nn n000) at cost 11.
- R7: Opcode 0xE9 loads `hl_value` at cost 5 with no push or pop.
- R8: Any other opcode gives `ctl_valid`=0, `redirect`=0, no strobes, next PC pc+1 and cost 0.
- R9: Results appear on the clock edge that samples `issue_valid` high. `redirect` is 1 exactly when the transfer is taken. Push and pop are one-cycle strobes and are never high together. While `issue_valid` is low, the result fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Opcode and operands are valid this cycle |
| opcode | input | 8 | Current opcode |
| flag_zero | input | 1 | Zero flag |
| flag_carry | input | 1 | Carry flag |
| flag_parity | input | 1 | Parity flag (1 = even) |
| flag_sign | input | 1 | Sign flag |
| cur_pc | input | 16 | Address of the current opcode |
| hl_value | input | 16 | HL register pair |
| operand | input | 16 | Two-byte immediate address |
| stack_top | input | 16 | Return address at the top of the stack |
| next_pc | output | 16 | Next program counter |
| ctl_valid | output | 1 | Last issued opcode was a control transfer |
| redirect | output | 1 | Transfer taken |
| push_req | output | 1 | One-cycle request to push `push_data` |
| pop_req | output | 1 | One-cycle request to pop the stack top |
| push_data | output | 16 | Return address to push |
| state_cost | output | 5 | Machine states charged for the instruction |

## Verification
The bench drives every one of the eight conditions with its flag both matching and not matching. A design that swapped the polarity of a condition, or picked the wrong flag, would jump where it should fall through. Calls and returns are run both taken and untaken, because a wrong design reports 17 or 11 regardless of the outcome, or pushes and pops on a false condition. Restart vectors 0, 5 and 7 are checked so that a misplaced nnn field shows up as a wrong address. The bench also confirms that the strobes fall after one cycle while the next PC holds, and that a non-branch opcode neither redirects nor disturbs the stack.

// File: rtl/brc_pkg.sv
// Shared types and state costs for the branch/next-PC unit.
package brc_pkg;
    typedef enum logic [2:0] {
        CK_NONE,
        CK_JUMP,
        CK_CALL,
        CK_RET,
        CK_RST,
        CK_PCHL
    } ctl_kind_e;

    localparam int COST_JUMP       = 10;
    localparam int COST_CALL_TAKEN = 17;
    localparam int COST_CALL_SKIP  = 11;
    localparam int COST_RET_PLAIN  = 10;
    localparam int COST_RET_TAKEN  = 11;
    localparam int COST_RET_SKIP   = 5;
    localparam int COST_RST        = 11;
    localparam int COST_PCHL       = 5;

    localparam int LEN_LONG  = 3;
    localparam int LEN_SHORT = 1;
    localparam int VEC_SHIFT = 3;
endpackage

// File: rtl/brc_cond_eval.sv
// Condition evaluator: turns a 3-bit condition code into a true/false result.
// Assumes: code bits [2:1] pick the flag and bit 0 is the required flag value.
module brc_cond_eval #(
    parameter int NUM_CODES = 8,
    localparam int CC_W     = $clog2(NUM_CODES)
) (
    input  logic [CC_W-1:0] cc,
    input  logic            flag_zero,
    input  logic            flag_carry,
    input  logic            flag_parity,
    input  logic            flag_sign,
    output logic            cond_true
);
    logic [3:0]           flag_vec;
    logic [NUM_CODES-1:0] code_hit;

    assign flag_vec = {flag_sign, flag_parity, flag_carry, flag_zero};

    // One comparator per condition code: selected flag equals wanted value.
    for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
        assign code_hit[i] = (flag_vec[i / 2] == 1'(i % 2));
    end

    assign cond_true = code_hit[cc];
endmodule

// File: rtl/brc_decode.sv
// Opcode classifier: identifies the control-transfer kind and its fields.
// Assumes: only the listed encodings are control transfers; all else is CK_NONE.
module brc_decode
    import brc_pkg::*;
(
    input  logic [7:0] opcode,
    output ctl_kind_e  kind,
    output logic       is_cond,
    output logic [2:0] cc,
    output logic [2:0] rst_idx
);
    // Classify by top two bits and low three bits, then middle field.
    always_comb begin
        kind    = CK_NONE;
        is_cond = 1'b0;
        cc      = opcode[5:3];
        rst_idx = opcode[5:3];
        if (opcode[7:6] == 2'b11) begin
            case (opcode[2:0])
                3'b000: begin kind = CK_RET;  is_cond = 1'b1; end
                3'b010: begin kind = CK_JUMP; is_cond = 1'b1; end
                3'b100: begin kind = CK_CALL; is_cond = 1'b1; end
                3'b111: kind = CK_RST;
                3'b011: if (opcode[5:3] == 3'b000) kind = CK_JUMP;
                3'b101: if (opcode[5:3] == 3'b001) kind = CK_CALL;
                3'b001: begin
                    if (opcode[5:3] == 3'b001) kind = CK_RET;
                    else if (opcode[5:3] == 3'b101) kind = CK_PCHL;
                end
                default: kind = CK_NONE;
            endcase
        end
    end
endmodule

// File: rtl/brc_target.sv
// Target selector: picks next PC, link address, stack strobes and state cost.
// Assumes: cond_true is meaningful only when is_cond is set.
module brc_target
    import brc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int COST_W = 5
) (
    input  ctl_kind_e         kind,
    input  logic              is_cond,
    input  logic              cond_true,
    input  logic [2:0]        rst_idx,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] hl,
    input  logic [ADDR_W-1:0] operand,
    input  logic [ADDR_W-1:0] stack_top,
    output logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] link,
    output logic [COST_W-1:0] cost,
    output logic              is_ctl,
    output logic              take,
    output logic              push,
    output logic              pop
);
    logic              cond_ok;
    logic [ADDR_W-1:0] seq_long;
    logic [ADDR_W-1:0] seq_short;

    assign cond_ok   = !is_cond || cond_true;
    assign seq_long  = pc + ADDR_W'(LEN_LONG);
    assign seq_short = pc + ADDR_W'(LEN_SHORT);

    // Per-kind selection of destination, strobes and cost.
    always_comb begin
        target = seq_short;
        link   = seq_short;
        cost   = '0;
        is_ctl = 1'b1;
        take   = 1'b0;
        push   = 1'b0;
        pop    = 1'b0;
        case (kind)
            CK_JUMP: begin
                take   = cond_ok;
                target = cond_ok ? operand : seq_long;
                link   = seq_long;
                cost   = COST_W'(COST_JUMP);
            end
            CK_CALL: begin
                take   = cond_ok;
                push   = cond_ok;
                target = cond_ok ? operand : seq_long;
                link   = seq_long;
                cost   = cond_ok ? COST_W'(COST_CALL_TAKEN) : COST_W'(COST_CALL_SKIP);
            end
            CK_RET: begin
                take   = cond_ok;
                pop    = cond_ok;
                target = cond_ok ? stack_top : seq_short;
                if (!is_cond)     cost = COST_W'(COST_RET_PLAIN);
                else if (cond_ok) cost = COST_W'(COST_RET_TAKEN);
                else              cost = COST_W'(COST_RET_SKIP);
            end
            CK_RST: begin
                take   = 1'b1;
                push   = 1'b1;
                target = ADDR_W'({rst_idx, VEC_SHIFT'(0)});
                cost   = COST_W'(COST_RST);
            end
            CK_PCHL: begin
                take   = 1'b1;
                target = hl;
                cost   = COST_W'(COST_PCHL);
            end
            default: is_ctl = 1'b0;
        endcase
    end
endmodule

// File: rtl/brc_nextpc.sv
// Branch condition and next-PC unit (top). Registers the decision one cycle
// after issue_valid; push/pop are single-cycle strobes.
// Assumes: the sequencer holds stack_top valid alongside any return opcode.
module brc_nextpc
    import brc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int COST_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [7:0]        opcode,
    input  logic              flag_zero,
    input  logic              flag_carry,
    input  logic              flag_parity,
    input  logic              flag_sign,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [ADDR_W-1:0] hl_value,
    input  logic [ADDR_W-1:0] operand,
    input  logic [ADDR_W-1:0] stack_top,
    output logic [ADDR_W-1:0] next_pc,
    output logic              ctl_valid,
    output logic              redirect,
    output logic              push_req,
    output logic              pop_req,
    output logic [ADDR_W-1:0] push_data,
    output logic [COST_W-1:0] state_cost
);
    ctl_kind_e         kind;
    logic              is_cond;
    logic [2:0]        cc;
    logic [2:0]        rst_idx;
    logic              cond_true;
    logic [ADDR_W-1:0] nx_target;
    logic [ADDR_W-1:0] nx_link;
    logic [COST_W-1:0] nx_cost;
    logic              nx_ctl;
    logic              nx_take;
    logic              nx_push;
    logic              nx_pop;

    brc_decode u_decode (
        .opcode  (opcode),
        .kind    (kind),
        .is_cond (is_cond),
        .cc      (cc),
        .rst_idx (rst_idx)
    );

    brc_cond_eval #(.NUM_CODES(8)) u_cond (
        .cc          (cc),
        .flag_zero   (flag_zero),
        .flag_carry  (flag_carry),
        .flag_parity (flag_parity),
        .flag_sign   (flag_sign),
        .cond_true   (cond_true)
    );

    brc_target #(.ADDR_W(ADDR_W), .COST_W(COST_W)) u_target (
        .kind      (kind),
        .is_cond   (is_cond),
        .cond_true (cond_true),
        .rst_idx   (rst_idx),
        .pc        (cur_pc),
        .hl        (hl_value),
        .operand   (operand),
        .stack_top (stack_top),
        .target    (nx_target),
        .link      (nx_link),
        .cost      (nx_cost),
        .is_ctl    (nx_ctl),
        .take      (nx_take),
        .push      (nx_push),
        .pop       (nx_pop)
    );

    // Result register: load on issue, hold otherwise; strobes self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc    <= '0;
            ctl_valid  <= 1'b0;
            redirect   <= 1'b0;
            push_req   <= 1'b0;
            pop_req    <= 1'b0;
            push_data  <= '0;
            state_cost <= '0;
        end else if (issue_valid) begin
            next_pc    <= nx_target;
            ctl_valid  <= nx_ctl;
            redirect   <= nx_take;
            push_req   <= nx_push;
            pop_req    <= nx_pop;
            push_data  <= nx_link;
            state_cost <= nx_cost;
        end else begin
            push_req   <= 1'b0;
            pop_req    <= 1'b0;
        end
    end
endmodule

// File: rtl/brc_nextpc_chk.sv
// Assertion checker for brc_nextpc, attached by bind below.
// Assumes: observes only the top-level ports.
module brc_nextpc_chk #(
    parameter int ADDR_W = 16,
    parameter int COST_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_valid,
    input logic [7:0]        opcode,
    input logic              flag_zero,
    input logic              flag_carry,
    input logic              flag_parity,
    input logic              flag_sign,
    input logic [ADDR_W-1:0] cur_pc,
    input logic [ADDR_W-1:0] hl_value,
    input logic [ADDR_W-1:0] operand,
    input logic [ADDR_W-1:0] stack_top,
    input logic [ADDR_W-1:0] next_pc,
    input logic              ctl_valid,
    input logic              redirect,
    input logic              push_req,
    input logic              pop_req,
    input logic [ADDR_W-1:0] push_data,
    input logic [COST_W-1:0] state_cost
);
    // R9: stack strobes never overlap.
    a_r9_push_pop_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_req && pop_req));

    // R9: a push strobe only follows an issue cycle and implies a taken transfer.
    a_r9_push_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |-> ($past(issue_valid) && redirect));

    // R9: a pop strobe only follows an issue cycle and implies a taken transfer.
    a_r9_pop_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req |-> ($past(issue_valid) && redirect));

    // R9: result fields hold while nothing is issued.
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !issue_valid) |-> ($stable(next_pc) && $stable(state_cost)));

    // R4: conditional call cost follows the outcome.
    a_r4_cond_call_cost: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && issue_valid && opcode[7:6] == 2'b11 && opcode[2:0] == 3'b100)
        |-> (redirect ? (state_cost == COST_W'(17) && push_req)
                      : (state_cost == COST_W'(11) && !push_req)));

    // R5: conditional return cost follows the outcome.
    a_r5_cond_ret_cost: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && issue_valid && opcode[7:6] == 2'b11 && opcode[2:0] == 3'b000)
        |-> (redirect ? (state_cost == COST_W'(11) && pop_req)
                      : (state_cost == COST_W'(5) && !pop_req)));

    // R6: restart vector is the middle field times eight, with a push.
    a_r6_restart_vector: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && issue_valid && opcode[7:6] == 2'b11 && opcode[2:0] == 3'b111)
        |-> (push_req && next_pc == ADDR_W'({$past(opcode[5:3]), 3'b000})));
endmodule

bind brc_nextpc brc_nextpc_chk #(.ADDR_W(ADDR_W), .COST_W(COST_W)) u_chk (.*);

// File: tb/brc_nextpc_bench.sv
`timescale 1ns/1ps
module brc_nextpc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [7:0]  opcode = '0;
    logic        flag_zero = 1'b0, flag_carry = 1'b0, flag_parity = 1'b0, flag_sign = 1'b0;
    logic [15:0] cur_pc = 16'h1234;
    logic [15:0] hl_value = 16'hBEEF;
    logic [15:0] operand = 16'h5678;
    logic [15:0] stack_top = 16'h0ABC;
    logic [15:0] next_pc, push_data;
    logic        ctl_valid, redirect, push_req, pop_req;
    logic [4:0]  state_cost;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    brc_nextpc u_brc_nextpc (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .opcode(opcode),
        .flag_zero(flag_zero), .flag_carry(flag_carry), .flag_parity(flag_parity),
        .flag_sign(flag_sign), .cur_pc(cur_pc), .hl_value(hl_value),
        .operand(operand), .stack_top(stack_top), .next_pc(next_pc),
        .ctl_valid(ctl_valid), .redirect(redirect), .push_req(push_req),
        .pop_req(pop_req), .push_data(push_data), .state_cost(state_cost)
    );

    // {opcode, flags{s,p,c,z}, ctl, redirect, push, pop, next_pc, cost}
    // pc=1234, operand=5678, hl=BEEF, stack_top=0ABC
    localparam int NV = 23;
    localparam logic [36:0] VEC [NV] = '{
        {8'hC3, 4'b0000, 4'b1100, 16'h5678, 5'd10},  // R3 jump
        {8'hC2, 4'b0000, 4'b1100, 16'h5678, 5'd10},  // R2 not zero, true
        {8'hC2, 4'b0001, 4'b1000, 16'h1237, 5'd10},  // R2 not zero, false
        {8'hCA, 4'b0001, 4'b1100, 16'h5678, 5'd10},  // R2 zero, true
        {8'hD2, 4'b0010, 4'b1000, 16'h1237, 5'd10},  // R2 no carry, false
        {8'hDA, 4'b0010, 4'b1100, 16'h5678, 5'd10},  // R2 carry, true
        {8'hE2, 4'b0100, 4'b1000, 16'h1237, 5'd10},  // R2 parity odd, false
        {8'hEA, 4'b0100, 4'b1100, 16'h5678, 5'd10},  // R2 parity even, true
        {8'hF2, 4'b1000, 4'b1000, 16'h1237, 5'd10},  // R2 plus, false
        {8'hFA, 4'b1000, 4'b1100, 16'h5678, 5'd10},  // R2 minus, true
        {8'hF2, 4'b0111, 4'b1100, 16'h5678, 5'd10},  // R2 plus, true
        {8'hCD, 4'b0000, 4'b1110, 16'h5678, 5'd17},  // R4 call
        {8'hC4, 4'b0000, 4'b1110, 16'h5678, 5'd17},  // R4 cond call taken
        {8'hCC, 4'b0000, 4'b1000, 16'h1237, 5'd11},  // R4 cond call skipped
        {8'hEC, 4'b1011, 4'b1000, 16'h1237, 5'd11},  // R4 call parity even skipped
        {8'hC9, 4'b0000, 4'b1101, 16'h0ABC, 5'd10},  // R5 return
        {8'hD0, 4'b0000, 4'b1101, 16'h0ABC, 5'd11},  // R5 cond return taken
        {8'hD8, 4'b0000, 4'b1000, 16'h1235, 5'd5},   // R5 cond return skipped
        {8'hF8, 4'b1000, 4'b1101, 16'h0ABC, 5'd11},  // R5 return on minus
        {8'hFF, 4'b0000, 4'b1110, 16'h0038, 5'd11},  // R6 vector 7
        {8'hC7, 4'b1111, 4'b1110, 16'h0000, 5'd11},  // R6 vector 0
        {8'hE9, 4'b0000, 4'b1100, 16'hBEEF, 5'd5},   // R7 load from HL
        {8'h41, 4'b1111, 4'b0000, 16'h1235, 5'd0}    // R8 non-branch
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one issue at a falling edge; result is checked at the next falling edge.
    task automatic issue(input logic [7:0] op, input logic [3:0] fl);
        @(negedge clk);
        opcode = op;
        {flag_sign, flag_parity, flag_carry, flag_zero} = fl;
        issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 next_pc", 32'(next_pc), 32'h0);
        chk("R1 strobes/flags", 32'({ctl_valid, redirect, push_req, pop_req}), 32'h0);
        chk("R1 cost", 32'(state_cost), 32'h0);
        rst_n = 1'b1;

        // Table walk: R2..R8
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][36:29], VEC[i][28:25]);
            chk($sformatf("R2-table v%0d ctl/redir/push/pop", i),
                32'({ctl_valid, redirect, push_req, pop_req}), 32'(VEC[i][24:21]));
            chk($sformatf("R3 table v%0d next_pc", i), 32'(next_pc), 32'(VEC[i][20:5]));
            chk($sformatf("R4 table v%0d cost", i), 32'(state_cost), 32'(VEC[i][4:0]));
        end

        // R4: call pushes pc+3; R9: strobe falls next cycle, result holds
        issue(8'hCD, 4'b0000);
        chk("R4 push_data", 32'(push_data), 32'h1237);
        @(negedge clk);
        chk("R9 push strobe one cycle", 32'(push_req), 32'h0);
        chk("R9 next_pc holds", 32'(next_pc), 32'h5678);
        chk("R9 cost holds", 32'(state_cost), 32'd17);

        // R6: restart pushes pc+1, vector 5
        issue(8'hEF, 4'b0000);
        chk("R6 vector 5", 32'(next_pc), 32'h0028);
        chk("R6 push_data", 32'(push_data), 32'h1235);

        // R5: pop strobe one cycle
        issue(8'hC9, 4'b0000);
        @(negedge clk);
        chk("R9 pop strobe one cycle", 32'(pop_req), 32'h0);
        chk("R5 return target holds", 32'(next_pc), 32'h0ABC);

        // R8: non-branch with other pc, no redirect, pc+1
        cur_pc = 16'hFFFF;
        issue(8'h00, 4'b0000);
        chk("R8 wrap pc+1", 32'(next_pc), 32'h0000);
        chk("R8 no transfer", 32'({ctl_valid, redirect, push_req, pop_req}), 32'h0);

        // R3: not-taken jump at pc wrap
        cur_pc = 16'hFFFE;
        issue(8'hCA, 4'b0000);
        chk("R3 skip wraps", 32'(next_pc), 32'h0001);

        // R1: reset mid-run clears
        issue(8'hCD, 4'b0000);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears pc", 32'(next_pc), 32'h0);
        chk("R1 reset clears cost", 32'(state_cost), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule